// File: doc/BRIEF.md
# Shared-Offset Mode Register Pair

This block sits next to a serial channel's datapath and holds its two 8-bit mode registers. Both registers answer at the same bus offset. An internal pointer chooses which of the two an access reaches. After reset the pointer selects the first mode register (MR1). Any read or write that reaches MR1 moves the pointer to the second register (MR2). Accesses to MR2 leave the pointer where it is, so software reaches MR2 repeatedly until the pointer is sent back.

Software sends the pointer back with a dedicated command input, `ptr_rst`. The block drives the MR1 contents and the decoded MR2 fields straight to the channel datapath.

MR2 has two layouts, chosen by the `uart_mode` input. In UART mode every bit is meaningful. In any other mode only the channel-mode field is live; the remaining bits read as zero and keep their stored value.

The bus interface is a plain single-cycle slave with no back-pressure: an access completes in the cycle its strobe is sampled. Read data is registered. No streamed data passes through the block, so no valid/ready handshake applies.

Top module: `mode_reg_access`

## Requirements
- R1: After reset the pointer selects MR1, MR1 and MR2 both hold 0x00, `rdata` is 0x00 and every decoded field output is 0.
- R2: An access is an edge where `cs` is 1, `rd` or `wr` is 1, and `addr` equals the offset parameter (default 0). Strobes with `cs` low or with any other address change no register, do not move the pointer, and leave `rdata` unchanged.
- R3: A read or write that reaches MR1 moves the pointer to MR2. An access in the very next cycle already reaches MR2.
- R4: A read or write that reaches MR2 leaves the pointer on MR2.
- R5: A high `ptr_rst` returns the pointer to MR1 for the next cycle. This overrides the move caused by an MR1 access in the same cycle; that access is still performed.
- R6: MR2 bits are numbered with bit 0 as the msb.
  - Bits 0:1 (`wdata[7:6]`) are the channel mode: 00 normal, 01 automatic echo, 10 local loop-back, 11 remote loop-back.
  - Bit 2 (`wdata[5]`) is automatic RTS release after the last transmitted character.
  - Bits 3:7 (`wdata[4:0]`) are a further UART control field.
  - `chan_mode`, `rts_auto` and `mr2_aux` show these fields.
- R7: While `uart_mode` is 0, MR2 bits 2:7 (`[5:0]`) read as 0, ignore writes and keep their stored value, and `rts_auto`/`mr2_aux` drive 0. The channel-mode field stays writable.
- R8: A read loads `rdata` at the same edge, from the register the pointer selected before that edge. `rdata` then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ptr_rst | input | 1 | Command: send pointer back to MR1 |
| uart_mode | input | 1 | 1 selects the UART layout of MR2 |
| mr1_q | output | 8 | MR1 contents |
| chan_mode | output | 2 | MR2 channel-mode field |
| rts_auto | output | 1 | MR2 automatic RTS release bit |
| mr2_aux | output | 5 | MR2 remaining UART control bits |

## Verification
Every cycle, the assertions check the pointer's behaviour:
- It moves to MR2 after an MR1 access.
- It holds during MR2 accesses and idle cycles.
- It yields to `ptr_rst`.

They also check that the reserved MR2 bits stay frozen and read as zero outside UART mode, and that `rdata` changes only on a read. Only the bench's scenarios can show that the right register receives each value, because that needs the whole history of values written. The same holds for back-to-back access timing and the field decoding seen at the outputs.

// File: rtl/mra_pkg.sv
package mra_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL      = 2'b00,
    CH_ECHO        = 2'b01,
    CH_LOCAL_LOOP  = 2'b10,
    CH_REMOTE_LOOP = 2'b11
  } chan_mode_e;

  typedef enum logic {
    SEL_MR1 = 1'b0,
    SEL_MR2 = 1'b1
  } mr_sel_e;
endpackage

// File: rtl/mra_ptr.sv
module mra_ptr
  import mra_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hit,
  input  logic    ptr_rst,
  output mr_sel_e sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sel <= SEL_MR1;
    else if (ptr_rst)            sel <= SEL_MR1;
    else if (hit && sel == SEL_MR1) sel <= SEL_MR2;
  end

  AST_PTR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> sel == SEL_MR1); // R5
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ptr_rst && sel == SEL_MR1) |=> sel == SEL_MR2); // R3
  AST_PTR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_rst && sel == SEL_MR2) |=> sel == SEL_MR2); // R4
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !ptr_rst) |=> $stable(sel)); // R2
endmodule

// File: rtl/mra_mr1_reg.sv
module mra_mr1_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  AST_MR1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R2
endmodule

// File: rtl/mra_mr2_reg.sv
module mra_mr2_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              uart_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] view,
  output logic [1:0]        chan_mode,
  output logic              rts_auto,
  output logic [DATA_W-4:0] aux
);
  localparam int MODE_LO = DATA_W - 2;
  localparam int RTS_BIT = DATA_W - 3;
  localparam logic [DATA_W-1:0] LIVE_MASK = {2'b11, {(DATA_W-2){1'b0}}};

  logic [DATA_W-1:0] store;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b >= MODE_LO) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  store[b] <= 1'b0;
        else if (we) store[b] <= wdata[b];
      end
    end else begin : g_uart_only
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               store[b] <= 1'b0;
        else if (we && uart_mode) store[b] <= wdata[b];
      end
    end
  end

  assign view      = uart_mode ? store : (store & LIVE_MASK);
  assign chan_mode = store[DATA_W-1:MODE_LO];
  assign rts_auto  = uart_mode & store[RTS_BIT];
  assign aux       = uart_mode ? store[RTS_BIT-1:0] : '0;

  AST_RSV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_mode |=> $stable(store[RTS_BIT:0])); // R7
  AST_MR2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(store)); // R4
endmodule

// File: rtl/mode_reg_access.sv
module mode_reg_access
  import mra_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] MR_OFFSET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              ptr_rst,
  input  logic              uart_mode,
  output logic [7:0]        mr1_q,
  output logic [1:0]        chan_mode,
  output logic              rts_auto,
  output logic [4:0]        mr2_aux
);
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] RSV_MASK = {2'b00, {(DATA_W-2){1'b1}}};

  mr_sel_e           sel;
  logic              hit, wr_hit, rd_hit;
  logic [DATA_W-1:0] mr2_view;

  assign hit    = cs && (rd || wr) && (addr == MR_OFFSET);
  assign wr_hit = hit && wr;
  assign rd_hit = hit && rd;

  mra_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ptr_rst(ptr_rst), .sel(sel)
  );

  mra_mr1_reg #(.DATA_W(DATA_W)) u_mr1 (
    .clk(clk), .rst_n(rst_n), .we(wr_hit && sel == SEL_MR1),
    .wdata(wdata), .q(mr1_q)
  );

  mra_mr2_reg #(.DATA_W(DATA_W)) u_mr2 (
    .clk(clk), .rst_n(rst_n), .we(wr_hit && sel == SEL_MR2),
    .uart_mode(uart_mode), .wdata(wdata), .view(mr2_view),
    .chan_mode(chan_mode), .rts_auto(rts_auto), .aux(mr2_aux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_hit) rdata <= (sel == SEL_MR1) ? mr1_q : mr2_view;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(rdata)); // R8
  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel == SEL_MR2 && !uart_mode) |=> (rdata & RSV_MASK) == '0); // R7
  AST_NO_MR1_WRITE_ON_MR2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MR2) |=> $stable(mr1_q)); // R4
endmodule

// File: tb/mode_reg_access_tb.sv
`timescale 1ns/1ps
module mode_reg_access_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, rd = 0, wr = 0, ptr_rst = 0, uart_mode = 1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, mr1_q;
  logic [1:0] chan_mode;
  logic       rts_auto;
  logic [4:0] mr2_aux;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mode_reg_access dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ptr_rst(ptr_rst), .uart_mode(uart_mode),
    .mr1_q(mr1_q), .chan_mode(chan_mode), .rts_auto(rts_auto), .mr2_aux(mr2_aux)
  );

  // {kind(0 write,1 read,2 ptr cmd), uart_mode, wdata, expected rdata}
  localparam logic [18:0] VEC [15] = '{
    {2'd0, 1'b1, 8'h5A, 8'h00},  // R3 write MR1
    {2'd1, 1'b1, 8'h00, 8'h00},  // R3 next cycle reaches MR2
    {2'd0, 1'b1, 8'hA7, 8'h00},  // R4 write MR2
    {2'd1, 1'b1, 8'h00, 8'hA7},  // R4 still MR2
    {2'd2, 1'b1, 8'h00, 8'h00},  // R5 pointer command
    {2'd1, 1'b1, 8'h00, 8'h5A},  // R5 MR1 again
    {2'd1, 1'b1, 8'h00, 8'hA7},  // R3 moved to MR2
    {2'd0, 1'b0, 8'h7F, 8'h00},  // R7 write, reserved ignored
    {2'd1, 1'b0, 8'h00, 8'h40},  // R7 reserved read 0
    {2'd1, 1'b1, 8'h00, 8'h67},  // R7 stored bits kept
    {2'd2, 1'b1, 8'h00, 8'h00},
    {2'd0, 1'b1, 8'h33, 8'h00},  // R3 write MR1
    {2'd1, 1'b1, 8'h00, 8'h67},  // R4 MR2 untouched
    {2'd2, 1'b1, 8'h00, 8'h00},
    {2'd1, 1'b1, 8'h00, 8'h33}   // R8 MR1 read back
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic r, input logic w, input logic p,
                       input logic u, input logic [3:0] a, input logic [7:0] d);
    cs = c; rd = r; wr = w; ptr_rst = p; uart_mode = u; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cs = 0; rd = 0; wr = 0; ptr_rst = 0; addr = '0; wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 mr1", mr1_q, 8'h00);
    chk("R1 fields", {chan_mode, rts_auto, mr2_aux}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 15; i++) begin
      logic [1:0] k;
      k = VEC[i][18:17];
      if (k == 2'd0)      drive(1, 0, 1, 0, VEC[i][16], 4'd0, VEC[i][15:8]);
      else if (k == 2'd1) drive(1, 1, 0, 0, VEC[i][16], 4'd0, 8'h00);
      else                drive(0, 0, 0, 1, VEC[i][16], 4'd0, 8'h00);
      if (k == 2'd1) chk($sformatf("R3/R4/R5/R7 vector %0d", i), rdata, VEC[i][7:0]);
    end
    idle();
    @(negedge clk);

    // R6 field decoding, MR2 = 0x67
    chk("R6 chan_mode", {6'd0, chan_mode}, 8'h01);
    chk("R6 rts_auto", {7'd0, rts_auto}, 8'h01);
    chk("R6 aux", {3'd0, mr2_aux}, 8'h07);
    chk("R3 mr1 port", mr1_q, 8'h33);
    uart_mode = 0;
    #1;
    chk("R7 rts off", {7'd0, rts_auto}, 8'h00);
    chk("R7 aux off", {3'd0, mr2_aux}, 8'h00);
    chk("R7 chan live", {6'd0, chan_mode}, 8'h01);
    uart_mode = 1;
    @(negedge clk);

    // R2 ignored strobes
    drive(0, 0, 0, 1, 1, 4'd0, 8'h00);
    drive(1, 0, 1, 0, 1, 4'd3, 8'hFF);
    drive(0, 1, 1, 0, 1, 4'd0, 8'hFF);
    drive(1, 1, 0, 0, 1, 4'd5, 8'h00);
    idle();
    chk("R2 mr1 kept", mr1_q, 8'h33);
    chk("R2 mr2 kept", {chan_mode, rts_auto, mr2_aux}, 8'h67);
    chk("R8 rdata held", rdata, 8'h33);
    drive(1, 1, 0, 0, 1, 4'd0, 8'h00);
    chk("R2 pointer not moved", rdata, 8'h33);

    // R5 command beats simultaneous MR1 access
    drive(0, 0, 0, 1, 1, 4'd0, 8'h00);
    drive(1, 0, 1, 1, 1, 4'd0, 8'h99);
    chk("R5 write done", mr1_q, 8'h99);
    drive(1, 1, 0, 0, 1, 4'd0, 8'h00);
    chk("R5 pointer on MR1", rdata, 8'h99);
    drive(1, 1, 0, 0, 1, 4'd0, 8'h00);
    chk("R3 pointer on MR2", rdata, 8'h67);
    idle();

    // R1 reset mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R1 rdata reset", rdata, 8'h00);
    chk("R1 mr1 reset", mr1_q, 8'h00);
    chk("R1 mr2 reset", {chan_mode, rts_auto, mr2_aux}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    drive(1, 0, 1, 0, 1, 4'd0, 8'hC0);
    chk("R1 first write to MR1", mr1_q, 8'hC0);
    drive(1, 1, 0, 0, 1, 4'd0, 8'h00);
    chk("R1 MR2 zero", rdata, 8'h00);
    idle();
    @(negedge clk);
    finish_run();
  end
endmodule